// File: doc/BRIEF.md
# Energy Detect Peak Scanner

This block runs a counted series of channel energy measurements and keeps the largest value. A start pulse launches a scan. The external measurement source then delivers raw samples on a valid-qualified input. The block counts the samples it accepts and tracks their maximum. When the last sample arrives, it stores the maximum in its result register and raises a single end pulse. One completion event per scan, rather than one per measurement, keeps the interrupt rate low.

The count input is captured when the scan starts. A count of N gives N+1 measurements, so a count of zero gives exactly one. A stop pulse abandons a running scan and raises no end pulse. A combinational output maps the stored result onto the 0 to 255 channel-scan scale. Raw values up to 63 are multiplied by 4. Larger values saturate to 255.

Top module: `ed_peak_scan`

## Requirements
- R1: A start pulse while idle makes busy_o high from the next cycle and clears the running maximum to 0, so a new scan's result never includes samples from earlier scans.
- R2: With the captured count N (21 bits), exactly N+1 valid samples are accepted before the scan ends. A count of 0 gives a single measurement, and end_o stays low after every sample except the last.
- R3: result_o (7 bits) becomes the largest sample accepted in the scan. It changes only in the cycle where end_o is high and otherwise holds its value.
- R4: end_o is a one-cycle pulse. It is high in the cycle after the clock edge that accepted the final sample, and busy_o falls on that same edge.
- R5: A start pulse while busy is ignored. The scan is not restarted, its maximum is kept and its remaining count is not reloaded.
- R6: A stop pulse while busy ends the scan on the next edge, with no end pulse, and result_o keeps its previous value. If stop and a valid sample arrive in the same cycle, stop wins.
- R7: Valid samples presented while idle are ignored. They raise no end pulse and do not change result_o.
- R8: scaled_o (8 bits) is 255 when result_o is greater than 63, and otherwise equals result_o multiplied by 4.
- R9: After reset, busy_o, end_o, result_o and scaled_o are all 0.
- R10: The count input is sampled only when a scan starts. Changing it during a scan does not change how many samples that scan accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start task pulse |
| stop_i | input | 1 | Stop task pulse; aborts a running scan |
| iter_cnt_i | input | 21 | Extra-iteration count, captured at start |
| smp_valid_i | input | 1 | Raw sample valid from the measurement source |
| smp_i | input | 7 | Raw energy sample |
| busy_o | output | 1 | Scan in progress |
| end_o | output | 1 | One-cycle end-of-scan event |
| result_o | output | 7 | Peak result register |
| scaled_o | output | 8 | Result on the 0..255 scan scale |

## Verification
The assertions check every cycle that end_o is a single-cycle pulse that coincides with busy_o falling. They also check that result_o moves only with end_o, that a stop while busy leaves no end pulse, and that busy_o rises only after a start. In addition they check that scaled_o is either saturated or a multiple of 4. The bench's scenarios are needed to show that exactly N+1 samples are counted, that the stored value is the true maximum, and that starts and count changes during a scan are ignored. The bench also sweeps the scaling over all 128 raw values.

// File: rtl/ed_scan_pkg.sv
package ed_scan_pkg;
  localparam int unsigned SMP_W     = 7;
  localparam int unsigned CNT_W     = 21;
  localparam int unsigned OUT_W     = 8;
  localparam int unsigned SAT_LIMIT = 63;
  localparam int unsigned SCALE_SH  = 2;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} scan_st_e;
endpackage

// File: rtl/ed_scale.sv
module ed_scale #(
  parameter int unsigned SMP_W     = ed_scan_pkg::SMP_W,
  parameter int unsigned OUT_W     = ed_scan_pkg::OUT_W,
  parameter int unsigned SAT_LIMIT = ed_scan_pkg::SAT_LIMIT,
  parameter int unsigned SCALE_SH  = ed_scan_pkg::SCALE_SH
) (
  input  logic [SMP_W-1:0] raw_i,
  output logic [OUT_W-1:0] scaled_o
);
  localparam logic [SMP_W-1:0] LIMIT = SMP_W'(SAT_LIMIT);

  logic [OUT_W-1:0] widened;
  assign widened = OUT_W'(raw_i);

  always_comb begin
    if (raw_i > LIMIT) scaled_o = '1;
    else               scaled_o = widened << SCALE_SH;
  end
endmodule

// File: rtl/ed_scan_seq.sv
module ed_scan_seq
  import ed_scan_pkg::*;
#(
  parameter int unsigned CNT_W = ed_scan_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] iter_cnt_i,
  input  logic             smp_valid_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             take_o,
  output logic             last_o,
  output logic             end_o
);
  scan_st_e         st_q;
  logic [CNT_W-1:0] remain_q;

  assign busy_o = (st_q == ST_RUN);
  assign clr_o  = !busy_o && start_i;
  // stop has priority over a same-cycle sample
  assign take_o = busy_o && smp_valid_i && !stop_i;
  assign last_o = take_o && (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      remain_q <= '0;
      end_o    <= 1'b0;
    end else begin
      end_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q     <= ST_RUN;
            remain_q <= iter_cnt_i;
          end
        end
        ST_RUN: begin
          if (stop_i) begin
            st_q <= ST_IDLE;
          end else if (last_o) begin
            st_q  <= ST_IDLE;
            end_o <= 1'b1;
          end else if (take_o) begin
            remain_q <= remain_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ed_peak_track.sv
module ed_peak_track #(
  parameter int unsigned SMP_W = ed_scan_pkg::SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             last_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] result_o
);
  logic [SMP_W-1:0] peak_q, peak_nxt;

  assign peak_nxt = (smp_i > peak_q) ? smp_i : peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q   <= '0;
      result_o <= '0;
    end else begin
      if (clr_i)       peak_q <= '0;
      else if (take_i) peak_q <= peak_nxt;
      if (last_i)      result_o <= peak_nxt;
    end
  end
endmodule

// File: rtl/ed_peak_scan.sv
module ed_peak_scan #(
  parameter int unsigned SMP_W     = ed_scan_pkg::SMP_W,
  parameter int unsigned CNT_W     = ed_scan_pkg::CNT_W,
  parameter int unsigned OUT_W     = ed_scan_pkg::OUT_W,
  parameter int unsigned SAT_LIMIT = ed_scan_pkg::SAT_LIMIT,
  parameter int unsigned SCALE_SH  = ed_scan_pkg::SCALE_SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] iter_cnt_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             busy_o,
  output logic             end_o,
  output logic [SMP_W-1:0] result_o,
  output logic [OUT_W-1:0] scaled_o
);
  logic clr, take, last;

  ed_scan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .iter_cnt_i  (iter_cnt_i),
    .smp_valid_i (smp_valid_i),
    .busy_o      (busy_o),
    .clr_o       (clr),
    .take_o      (take),
    .last_o      (last),
    .end_o       (end_o)
  );

  ed_peak_track #(.SMP_W(SMP_W)) u_peak (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .take_i   (take),
    .last_i   (last),
    .smp_i    (smp_i),
    .result_o (result_o)
  );

  ed_scale #(
    .SMP_W(SMP_W), .OUT_W(OUT_W), .SAT_LIMIT(SAT_LIMIT), .SCALE_SH(SCALE_SH)
  ) u_scale (
    .raw_i    (result_o),
    .scaled_o (scaled_o)
  );
endmodule

// File: rtl/ed_peak_scan_chk.sv
module ed_peak_scan_chk #(
  parameter int unsigned SMP_W     = ed_scan_pkg::SMP_W,
  parameter int unsigned OUT_W     = ed_scan_pkg::OUT_W,
  parameter int unsigned SAT_LIMIT = ed_scan_pkg::SAT_LIMIT,
  parameter int unsigned SCALE_SH  = ed_scan_pkg::SCALE_SH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             busy_o,
  input logic             end_o,
  input logic [SMP_W-1:0] result_o,
  input logic [OUT_W-1:0] scaled_o
);
  localparam logic [SMP_W-1:0] LIMIT = SMP_W'(SAT_LIMIT);
  localparam logic [SCALE_SH-1:0] LOW_ZERO = '0;

  assert_end_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);

  assert_end_busy_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (!busy_o && $past(busy_o)));

  assert_result_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_o |-> $stable(result_o));

  assert_busy_needs_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_stop_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> (!busy_o && !end_o));

  assert_idle_no_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !end_o);

  assert_scale_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o > LIMIT) |-> (scaled_o == '1));

  assert_scale_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scaled_o != '1) |-> (scaled_o[SCALE_SH-1:0] == LOW_ZERO));
endmodule

bind ed_peak_scan ed_peak_scan_chk #(
  .SMP_W(SMP_W), .OUT_W(OUT_W), .SAT_LIMIT(SAT_LIMIT), .SCALE_SH(SCALE_SH)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .busy_o   (busy_o),
  .end_o    (end_o),
  .result_o (result_o),
  .scaled_o (scaled_o)
);

// File: tb/ed_peak_scan_tb.sv
module ed_peak_scan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [20:0] iter_cnt_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [6:0]  smp_i = '0;
  logic        busy_o, end_o;
  logic [6:0]  result_o;
  logic [7:0]  scaled_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  ed_peak_scan u_dut (
    .clk_i, .rst_ni, .start_i, .stop_i, .iter_cnt_i,
    .smp_valid_i, .smp_i, .busy_o, .end_o, .result_o, .scaled_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_scale(input int v);
    return (v > 63) ? 255 : v * 4;
  endfunction

  function automatic int gen(input int seed, input int k);
    return (seed * 37 + k * 53 + (k * k) % 11) % 128;
  endfunction

  task automatic do_start(input int cnt);
    @(negedge clk_i);
    start_i = 1'b1;
    iter_cnt_i = 21'(cnt);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // one valid sample; returns at the negedge after the accepting edge
  task automatic send(input int s, input bit gap);
    if (gap) @(negedge clk_i);
    @(negedge clk_i);
    smp_valid_i = 1'b1;
    smp_i = 7'(s);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    smp_i = 7'(127 - s);
  endtask

  task automatic run_scan(input int cnt, input int seed);
    int mx = 0;
    int early = 0;
    do_start(cnt);
    chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
    for (int k = 0; k <= cnt; k++) begin
      int s = gen(seed, k);
      if (s > mx) mx = s;
      send(s, k[0]);
      if (k < cnt && end_o) early++;
    end
    chk(early == 0, "R2 no early end", early, 0);
    chk(end_o == 1'b1, "R2 end after N+1 samples", int'(end_o), 1);
    chk(busy_o == 1'b0, "R4 busy falls with end", int'(busy_o), 0);
    chk(int'(result_o) == mx, "R3 peak result", int'(result_o), mx);
    @(negedge clk_i);
    chk(end_o == 1'b0, "R4 end is one cycle", int'(end_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && end_o == 0, "R9 reset flags", int'({busy_o, end_o}), 0);
    chk(result_o == 0 && scaled_o == 0, "R9 reset result", int'(scaled_o), 0);
    rst_ni = 1'b1;

    // R7: idle samples ignored
    send(99, 1'b0);
    chk(end_o == 0, "R7 no end when idle", int'(end_o), 0);
    chk(result_o == 0, "R7 result untouched", int'(result_o), 0);

    // R2/R3: several counts, including 0 and a long one
    run_scan(0, 3);
    run_scan(1, 7);
    run_scan(5, 11);
    run_scan(17, 23);
    run_scan(1000, 41);

    // R1: peak cleared at start; previous scan had a large value
    run_scan(2, 5);
    do_start(0);
    send(2, 1'b0);
    chk(result_o == 2, "R1 peak cleared at start", int'(result_o), 2);

    // R5 and R10: restart attempt and count change mid-scan
    do_start(3);
    send(100, 1'b0);
    do_start(0);
    iter_cnt_i = 21'd0;
    send(10, 1'b0);
    chk(end_o == 0, "R5 start while busy ignored", int'(end_o), 0);
    send(20, 1'b0);
    chk(end_o == 0, "R10 count change ignored", int'(end_o), 0);
    send(30, 1'b1);
    chk(end_o == 1, "R10 end after original count", int'(end_o), 1);
    chk(result_o == 100, "R5 peak kept across ignored start", int'(result_o), 100);

    // R6: stop aborts, stop beats same-cycle sample
    do_start(2);
    send(120, 1'b0);
    @(negedge clk_i);
    stop_i = 1'b1;
    smp_valid_i = 1'b1;
    smp_i = 7'd127;
    @(negedge clk_i);
    stop_i = 1'b0;
    smp_valid_i = 1'b0;
    chk(busy_o == 0, "R6 stop clears busy", int'(busy_o), 0);
    chk(end_o == 0, "R6 no end on stop", int'(end_o), 0);
    send(50, 1'b0);
    send(60, 1'b0);
    chk(end_o == 0, "R6 no late end", int'(end_o), 0);
    chk(result_o == 100, "R6 result kept", int'(result_o), 100);

    // R8: sweep all raw values via single-measurement scans
    for (int v = 0; v < 128; v++) begin
      do_start(0);
      send(v, 1'b0);
      chk(end_o == 1 && int'(result_o) == v, "R2 single measurement", int'(result_o), v);
      chk(int'(scaled_o) == exp_scale(v), "R8 scale", int'(scaled_o), exp_scale(v));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule